// File: doc/BRIEF.md
# Serial Write Master for an External Display Controller

This block drives an external display controller over a three-wire, write-only serial link. The link has a clock, a data line and a select line. A host issues one command at a time through a valid/op handshake and watches `busy`. A transmit command shifts a counted field of a data word out on the data line, most significant bit first. Two further commands control the select line on their own: one gives a single high pulse and one raises the line and leaves it high. The select line is never framed around a transfer automatically.

The speed of the serial clock comes from a 3-bit setting. One half-period lasts `HALF_BASE + HALF_STEP * speed` system clocks, which is 1 + 4·speed with the default values. Each of the three serial signals can be switched onto its own group of display pins. All pins in a group carry the same level, so the group gives more drive strength than a single pin. The link shares those pins with the multiplexed display drive. The link therefore works only while a nonzero duty mode is selected. While the duty mode is zero, every pin group is held low and all commands are refused.

Top module: `disp_spi_master`

## Requirements
- R1: After reset, `busy` is 0 and every pin of `pin_sck`, `pin_ssn` and `pin_sdo` is 0.
- R2: A transmit command (`cmd_op` = 0) with bit count n sends bits `cmd_data[n-1]` down to `cmd_data[0]` in that order. Each bit is placed on the data line at the acceptance edge or at the falling edge of the serial clock that ends the previous bit. Data bits above n-1 are not sent.
- R3: The serial clock idles low. Each bit spends H = 1 + 4·`speed` system clocks low and then H clocks high. H is latched when the command is accepted.
- R4: `busy` goes high at the clock edge that accepts a transmit command and stays high for exactly 2·H·n cycles. When it falls, the serial clock and the data line are both low.
- R5: A pulse command (`cmd_op` = 1) drives the select line high for H cycles and then low. `busy` is high for those same H cycles.
- R6: A set command (`cmd_op` = 2) drives the select line high and it stays high until a later pulse command. `busy` is high for H cycles. The select line keeps its level during transmit commands.
- R7: A command offered while `busy` is high is ignored. It changes neither the running operation, nor its length, nor the select level.
- R8: A transmit command with n = 0 or n > `DATA_W` is ignored, and so is op code 3. `busy` stays low.
- R9: While `duty_mode` is 0, commands are refused and all three pin groups are held at 0.
- R10: `route_en` bit 0 routes the serial clock, bit 1 the select line and bit 2 the data line. Each routed signal drives all `PINS` pins of its group with the same level. An unrouted group is held at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered this cycle |
| cmd_op | input | 2 | 0 transmit, 1 select pulse, 2 select set, 3 no operation |
| cmd_data | input | DATA_W | Word to transmit |
| cmd_bits | input | CNT_W | Number of bits to transmit (1..DATA_W) |
| speed | input | SPD_W | Half-period setting, 0 fastest |
| route_en | input | 3 | Pin group enables: bit0 clock, bit1 select, bit2 data |
| duty_mode | input | 2 | Display duty mode; 0 disables the link |
| busy | output | 1 | Operation in progress |
| pin_sck | output | PINS | Serial clock pin group |
| pin_ssn | output | PINS | Select line pin group |
| pin_sdo | output | PINS | Serial data pin group |

## Verification
The bench builds the block with `DATA_W` = 16 and six pins per group. Because the word is short, transfers of the full word length (n = 16) at the slowest speed (H = 29) fit in the run. So do single-bit transfers and the out-of-range counts 0 and 17. The speed setting keeps its full 3-bit width. This puts both extreme half-periods, 1 clock and 29 clocks, within reach, together with a mid-range half-period. Combining the set command, pulses, refused commands and changes to routing and duty mode during a transfer covers every pin group in both its routed and its forced-low state.

// File: rtl/dsm_pkg.sv
package dsm_pkg;

  typedef enum logic [1:0] {
    OP_SEND  = 2'd0,
    OP_PULSE = 2'd1,
    OP_SET   = 2'd2,
    OP_NONE  = 2'd3
  } dsm_op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOW  = 2'd1,
    ST_HIGH = 2'd2,
    ST_SEL  = 2'd3
  } dsm_state_e;

  // Length of one serial clock half in system clocks.
  function automatic int unsigned half_cycles(input int unsigned spd,
                                              input int unsigned base,
                                              input int unsigned step);
    return base + step * spd;
  endfunction

  // Left shift that lifts an n-bit field to the top of the word.
  function automatic int unsigned field_shift(input int unsigned width,
                                              input int unsigned nbits);
    return width - nbits;
  endfunction

endpackage

// File: rtl/dsm_timer.sv
module dsm_timer #(
  parameter int SPD_W     = 3,
  parameter int HALF_BASE = 1,
  parameter int HALF_STEP = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             run,
  input  logic [SPD_W-1:0] speed,
  output logic             tick
);
  import dsm_pkg::*;

  localparam int unsigned MAX_HALF =
    half_cycles((32'd1 << SPD_W) - 32'd1, HALF_BASE, HALF_STEP);
  localparam int CW = $clog2(MAX_HALF + 1);

  logic [SPD_W-1:0] spd_q;
  logic [CW-1:0]    cnt_q;
  logic [CW-1:0]    reload_new;
  logic [CW-1:0]    reload_held;

  assign reload_new  = CW'(half_cycles(32'(speed), HALF_BASE, HALF_STEP) - 32'd1);
  assign reload_held = CW'(half_cycles(32'(spd_q), HALF_BASE, HALF_STEP) - 32'd1);

  assign tick = run && !restart && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      spd_q <= '0;
      cnt_q <= '0;
    end else if (restart) begin
      spd_q <= speed;
      cnt_q <= reload_new;
    end else if (run) begin
      if (cnt_q == '0) cnt_q <= reload_held;
      else             cnt_q <= cnt_q - CW'(1);
    end
  end

endmodule

// File: rtl/dsm_shifter.sv
module dsm_shifter #(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] data,
  input  logic [CNT_W-1:0]  nbits,
  input  logic              shift,
  output logic              msb,
  output logic              last
);
  import dsm_pkg::*;

  logic [DATA_W-1:0] sreg_q;
  logic [CNT_W-1:0]  left_q;

  assign msb  = sreg_q[DATA_W-1];
  assign last = (left_q == CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg_q <= '0;
      left_q <= '0;
    end else if (load) begin
      sreg_q <= data << field_shift(DATA_W, 32'(nbits));
      left_q <= nbits;
    end else if (shift) begin
      sreg_q <= sreg_q << 1;
      left_q <= left_q - CNT_W'(1);
    end
  end

endmodule

// File: rtl/dsm_fanout.sv
module dsm_fanout #(
  parameter int PINS = 6
) (
  input  logic            sig,
  input  logic            en,
  output logic [PINS-1:0] pins
);
  for (genvar p = 0; p < PINS; p++) begin : g_pin
    assign pins[p] = sig & en;
  end
endmodule

// File: rtl/disp_spi_master.sv
module disp_spi_master #(
  parameter int DATA_W    = 32,
  parameter int CNT_W     = $clog2(DATA_W + 1),
  parameter int SPD_W     = 3,
  parameter int HALF_BASE = 1,
  parameter int HALF_STEP = 4,
  parameter int PINS      = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic [DATA_W-1:0] cmd_data,
  input  logic [CNT_W-1:0]  cmd_bits,
  input  logic [SPD_W-1:0]  speed,
  input  logic [2:0]        route_en,
  input  logic [1:0]        duty_mode,
  output logic              busy,
  output logic [PINS-1:0]   pin_sck,
  output logic [PINS-1:0]   pin_ssn,
  output logic [PINS-1:0]   pin_sdo
);
  import dsm_pkg::*;

  localparam int GROUPS = 3;

  dsm_state_e state_q;
  logic       sck_q;
  logic       ssn_q;
  logic       keep_q;
  logic       sdo_q;

  // named internal events
  logic link_on;
  logic op_ok;
  logic accept_ev;
  logic half_tick;
  logic shift_ev;
  logic frame_done;
  logic shf_msb;
  logic shf_last;
  dsm_op_e op_in;

  assign op_in   = dsm_op_e'(cmd_op);
  assign link_on = (duty_mode != 2'd0);

  always_comb begin
    case (op_in)
      OP_SEND:  op_ok = (cmd_bits != '0) && (32'(cmd_bits) <= DATA_W);
      OP_PULSE: op_ok = 1'b1;
      OP_SET:   op_ok = 1'b1;
      default:  op_ok = 1'b0;
    endcase
  end

  assign accept_ev  = cmd_valid && (state_q == ST_IDLE) && link_on && op_ok;
  assign shift_ev   = (state_q == ST_HIGH) && half_tick && !shf_last;
  assign frame_done = (state_q == ST_HIGH) && half_tick && shf_last;
  assign busy       = (state_q != ST_IDLE);
  assign sdo_q      = ((state_q == ST_LOW) || (state_q == ST_HIGH)) && shf_msb;

  dsm_timer #(
    .SPD_W    (SPD_W),
    .HALF_BASE(HALF_BASE),
    .HALF_STEP(HALF_STEP)
  ) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .restart(accept_ev),
    .run    (busy),
    .speed  (speed),
    .tick   (half_tick)
  );

  dsm_shifter #(
    .DATA_W(DATA_W),
    .CNT_W (CNT_W)
  ) u_shift (
    .clk  (clk),
    .rst_n(rst_n),
    .load (accept_ev && (op_in == OP_SEND)),
    .data (cmd_data),
    .nbits(cmd_bits),
    .shift(shift_ev),
    .msb  (shf_msb),
    .last (shf_last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      sck_q   <= 1'b0;
      ssn_q   <= 1'b0;
      keep_q  <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (accept_ev) begin
            if (op_in == OP_SEND) begin
              state_q <= ST_LOW;
            end else begin
              state_q <= ST_SEL;
              ssn_q   <= 1'b1;
              keep_q  <= (op_in == OP_SET);
            end
          end
        end
        ST_LOW: begin
          if (half_tick) begin
            sck_q   <= 1'b1;
            state_q <= ST_HIGH;
          end
        end
        ST_HIGH: begin
          if (half_tick) begin
            sck_q   <= 1'b0;
            state_q <= frame_done ? ST_IDLE : ST_LOW;
          end
        end
        default: begin
          if (half_tick) begin
            ssn_q   <= keep_q;
            state_q <= ST_IDLE;
          end
        end
      endcase
    end
  end

  // Group order follows route_en: clock, select, data.
  logic [GROUPS-1:0]    grp_sig;
  logic [PINS-1:0]      grp_pins [GROUPS];

  assign grp_sig = {sdo_q, ssn_q, sck_q};

  for (genvar g = 0; g < GROUPS; g++) begin : g_group
    dsm_fanout #(.PINS(PINS)) u_fan (
      .sig (grp_sig[g]),
      .en  (route_en[g] && link_on),
      .pins(grp_pins[g])
    );
  end

  assign pin_sck = grp_pins[0];
  assign pin_ssn = grp_pins[1];
  assign pin_sdo = grp_pins[2];

endmodule

// File: rtl/dsm_checker.sv
module dsm_checker #(
  parameter int PINS = 6
) (
  input logic            clk,
  input logic            rst_n,
  input logic            busy,
  input logic            sck_q,
  input logic            sdo_q,
  input logic            ssn_q,
  input logic            tick,
  input logic            accept,
  input logic [1:0]      duty_mode,
  input logic [PINS-1:0] pin_sck,
  input logic [PINS-1:0] pin_ssn,
  input logic [PINS-1:0] pin_sdo
);

  // R4
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!sck_q && !sdo_q));

  // R7
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !tick) |=> busy);

  // R3
  sck_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(sck_q));

  // R6
  ssn_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ssn_q) |-> $past(accept));

  // R9
  duty_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (duty_mode == 2'd0) |-> ((pin_sck == '0) && (pin_ssn == '0) && (pin_sdo == '0)));

  // R10
  group_uniform_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (($countones(pin_sck) == 0) || ($countones(pin_sck) == PINS)) &&
    (($countones(pin_ssn) == 0) || ($countones(pin_ssn) == PINS)) &&
    (($countones(pin_sdo) == 0) || ($countones(pin_sdo) == PINS)));

endmodule

bind disp_spi_master dsm_checker #(.PINS(PINS)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .busy     (busy),
  .sck_q    (sck_q),
  .sdo_q    (sdo_q),
  .ssn_q    (ssn_q),
  .tick     (half_tick),
  .accept   (accept_ev),
  .duty_mode(duty_mode),
  .pin_sck  (pin_sck),
  .pin_ssn  (pin_ssn),
  .pin_sdo  (pin_sdo)
);

// File: tb/disp_spi_master_tb.sv
`timescale 1ns/1ps
module disp_spi_master_tb;
  localparam int DW = 16;
  localparam int CW = $clog2(DW + 1);
  localparam int NP = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_valid = 1'b0;
  logic [1:0]    cmd_op = 2'd3;
  logic [DW-1:0] cmd_data = '0;
  logic [CW-1:0] cmd_bits = '0;
  logic [2:0]    speed = 3'd0;
  logic [2:0]    route_en = 3'b111;
  logic [1:0]    duty_mode = 2'd3;
  logic          busy;
  logic [NP-1:0] pin_sck, pin_ssn, pin_sdo;

  int checks = 0;
  int errors = 0;
  bit started = 1'b0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  disp_spi_master #(.DATA_W(DW), .PINS(NP)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_data(cmd_data), .cmd_bits(cmd_bits), .speed(speed),
    .route_en(route_en), .duty_mode(duty_mode), .busy(busy),
    .pin_sck(pin_sck), .pin_ssn(pin_ssn), .pin_sdo(pin_sdo)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural timeline model ----------------
  int cyc = 0, m_at = 0, m_h = 1, m_n = 0, m_op = 3;
  logic [DW-1:0] m_data = '0;
  bit m_base = 1'b0;

  function automatic bit m_busy(input int c);
    int e = c - m_at;
    if (m_op == 0) return e < 2 * m_h * m_n;
    if (m_op == 1 || m_op == 2) return e < m_h;
    return 1'b0;
  endfunction

  function automatic bit m_sck(input int c);
    int e = c - m_at;
    if (m_op == 0 && m_busy(c)) return (e % (2 * m_h)) >= m_h;
    return 1'b0;
  endfunction

  function automatic bit m_sdo(input int c);
    int e = c - m_at;
    if (m_op == 0 && m_busy(c)) return m_data[m_n - 1 - e / (2 * m_h)];
    return 1'b0;
  endfunction

  function automatic bit m_ssn(input int c);
    int e = c - m_at;
    if (m_op == 1) return e < m_h;
    if (m_op == 2) return 1'b1;
    return m_base;
  endfunction

  function automatic logic [NP-1:0] m_pins(input bit s, input int b);
    return (route_en[b] && duty_mode != 2'd0 && s) ? {NP{1'b1}} : {NP{1'b0}};
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc = 0; m_at = 0; m_op = 3; m_base = 1'b0; m_h = 1; m_n = 0;
    end else begin
      bit was_busy, cur_ssn, ok_op;
      was_busy = m_busy(cyc);
      cur_ssn  = m_ssn(cyc);
      cyc++;
      ok_op = (cmd_op == 2'd1) || (cmd_op == 2'd2) ||
              (cmd_op == 2'd0 && cmd_bits >= 1 && int'(cmd_bits) <= DW);
      if (!was_busy && cmd_valid && duty_mode != 2'd0 && ok_op) begin
        m_base = cur_ssn;
        m_op   = int'(cmd_op);
        m_at   = cyc;
        m_h    = 1 + 4 * int'(speed);
        m_n    = int'(cmd_bits);
        m_data = cmd_data;
      end
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n && started && !done) begin
      check(busy == m_busy(cyc), "R4 busy", busy, m_busy(cyc));
      check(pin_sck == m_pins(m_sck(cyc), 0), "R3 pin_sck", pin_sck, m_pins(m_sck(cyc), 0));
      check(pin_sdo == m_pins(m_sdo(cyc), 2), "R2 pin_sdo", pin_sdo, m_pins(m_sdo(cyc), 2));
      check(pin_ssn == m_pins(m_ssn(cyc), 1), "R5/R6 pin_ssn", pin_ssn, m_pins(m_ssn(cyc), 1));
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic issue(input logic [1:0] op, input logic [DW-1:0] d, input int n);
    @(negedge clk); #1;
    cmd_op = op; cmd_data = d; cmd_bits = CW'(n); cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = 2'd3;
  endtask

  task automatic busy_len(output int len);
    len = 0;
    while (busy) begin
      len++;
      @(negedge clk);
    end
  endtask

  task automatic run_cmd(input logic [1:0] op, input logic [DW-1:0] d, input int n, output int len);
    issue(op, d, n);
    busy_len(len);
  endtask

  initial begin : watchdog
    #(5ns * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    int len;
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(busy == 1'b0, "R1 busy after reset", busy, 0);
    check({pin_sck, pin_ssn, pin_sdo} == '0, "R1 pins after reset",
          {pin_sck, pin_ssn, pin_sdo}, 0);
    started = 1'b1;

    // R2 R4 fastest speed, 8 bits
    speed = 3'd0;
    run_cmd(2'd0, 16'h00A5, 8, len);
    check(len == 16, "R4 busy length speed0 n8", len, 16);

    // R3 R4 slowest speed, full word
    speed = 3'd7;
    run_cmd(2'd0, 16'hBEEF, 16, len);
    check(len == 2 * 29 * 16, "R4 busy length speed7 n16", len, 2 * 29 * 16);

    // R2 upper data bits ignored, 5-bit field
    speed = 3'd2;
    run_cmd(2'd0, 16'hFFF3, 5, len);
    check(len == 2 * 9 * 5, "R2 busy length n5", len, 90);

    // single bit
    speed = 3'd0;
    run_cmd(2'd0, 16'h0001, 1, len);
    check(len == 2, "R4 busy length n1", len, 2);

    // R5 pulse
    speed = 3'd1;
    run_cmd(2'd1, '0, 0, len);
    check(len == 5, "R5 pulse busy length", len, 5);
    check(pin_ssn == '0, "R5 select low after pulse", pin_ssn, 0);

    // R6 set, then transmit keeps the level
    run_cmd(2'd2, '0, 0, len);
    check(len == 5, "R6 set busy length", len, 5);
    check(pin_ssn == {NP{1'b1}}, "R6 select high after set", pin_ssn, 6'h3F);
    run_cmd(2'd0, 16'h0ACE, 12, len);
    check(pin_ssn == {NP{1'b1}}, "R6 select held across transmit", pin_ssn, 6'h3F);
    run_cmd(2'd1, '0, 0, len);
    check(pin_ssn == '0, "R6 pulse returns select low", pin_ssn, 0);

    // R7 commands during busy are ignored
    speed = 3'd3;
    issue(2'd0, 16'h0009, 4);
    len = 1;
    repeat (9) begin @(negedge clk); len++; end
    #1 cmd_op = 2'd2; cmd_valid = 1'b1;
    @(negedge clk); len++;
    cmd_op = 2'd0; cmd_bits = CW'(3);
    @(negedge clk); len++;
    cmd_valid = 1'b0; cmd_op = 2'd3;
    while (busy) begin @(negedge clk); len++; end
    len--;
    check(len == 2 * 13 * 4, "R7 length unchanged by ignored commands", len, 104);
    check(pin_ssn == '0, "R7 select unchanged by ignored set", pin_ssn, 0);
    check(busy == 1'b0, "R7 no queued command started", busy, 0);

    // R8 invalid commands
    speed = 3'd0;
    issue(2'd0, 16'hFFFF, 0);
    check(busy == 1'b0, "R8 zero bit count ignored", busy, 0);
    issue(2'd0, 16'hFFFF, DW + 1);
    check(busy == 1'b0, "R8 oversize bit count ignored", busy, 0);
    issue(2'd3, 16'hFFFF, 4);
    check(busy == 1'b0, "R8 op 3 ignored", busy, 0);

    // R9 duty mode zero
    run_cmd(2'd2, '0, 0, len);
    #1 duty_mode = 2'd0;
    @(negedge clk);
    check(pin_ssn == '0, "R9 pins forced low", pin_ssn, 0);
    issue(2'd1, '0, 0);
    check(busy == 1'b0, "R9 command refused", busy, 0);
    #1 duty_mode = 2'd1;
    @(negedge clk);
    check(pin_ssn == {NP{1'b1}}, "R9 select level kept", pin_ssn, 6'h3F);

    // R10 routing
    #1 route_en = 3'b010;
    @(negedge clk);
    check(pin_ssn == {NP{1'b1}} && pin_sck == '0, "R10 only select routed",
          {pin_ssn, pin_sck}, 12'hFC0);
    #1 route_en = 3'b101;
    speed = 3'd1;
    issue(2'd0, 16'h00C3, 8);
    check(pin_ssn == '0, "R10 unrouted select held low", pin_ssn, 0);
    busy_len(len);
    #1 route_en = 3'b111;
    run_cmd(2'd1, '0, 0, len);
    repeat (3) @(negedge clk);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule